// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Set-Less-Than

This block is a purely combinational ALU. It is built from a row of identical one-bit slices, one per bit position, chained as a ripple-carry adder. It computes AND, OR, addition, subtraction and a signed set-less-than on two operands.

Each slice holds the following logic:
- an AND gate and an OR gate on the raw operand bits;
- a full adder whose B input passes through a selectable inverter;
- a four-way selector that picks the slice's output.

A shared B-invert control and the top-level carry-in together turn the adder into a subtractor. Set-less-than is formed inside the chain. The signed-corrected sign of the top slice's difference is routed back as the "less" input of bit 0, and every other slice's less input is tied to zero.

The surrounding datapath supplies the operands and an operation code. It reads the result together with the adder's carry-out and signed-overflow flag. Neither flag depends on the operation code.

Top module: `bitslice_alu`

## Requirements
- R1: With op_sel = 2'b00 the result is the bitwise AND of a_in and b_in. b_flip has no effect on this result.
- R2: With op_sel = 2'b01 the result is the bitwise OR of a_in and b_in. b_flip has no effect on this result.
- R3: With op_sel = 2'b10 and b_flip = 0, {carry_out, result} equals a_in + b_in + carry_in, taken as an unsigned sum one bit wider than the operands.
- R4: With op_sel = 2'b10, b_flip = 1 and carry_in = 1, the result is a_in − b_in modulo 2^WIDTH. In this configuration carry_out is 1 exactly when a_in ≥ b_in as unsigned numbers.
- R5: ovf is 1 exactly when the adder's two's-complement sum of a_in, the possibly inverted b_in and carry_in overflows. That is the case when the carry into the top bit differs from the carry out of it.
- R6: With op_sel = 2'b11, b_flip = 1 and carry_in = 1, result[0] is 1 exactly when a_in < b_in as signed numbers. This holds also when the subtraction overflows.
- R7: With op_sel = 2'b11, every result bit above bit 0 is 0.
- R8: carry_out and ovf always reflect the adder for the current a_in, b_in, b_flip and carry_in, whatever op_sel is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand, optionally inverted into the adder |
| b_flip | input | 1 | Inverts b_in on the adder path of every slice |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | 00 AND, 01 OR, 10 adder sum, 11 less-than |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| ovf | output | 1 | Signed overflow of the adder |

## Verification
The bench builds two copies of the block.

The first copy uses WIDTH = 32. It is fed a table of directed vectors, including the largest positive and most negative operands compared both ways, equal operands and carries that ripple through every slice. Random operand pairs across all five operations follow.

The second copy uses WIDTH = 4. It makes every combination of operands, b_flip, carry_in and op_sel reachable, so each overflow and less-than corner is covered exhaustively at a small width.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             b_flip,
  input  logic             carry_in,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf
);
  logic set_bit;

  for (genvar i = 0; i < WIDTH; i++) begin : slice
    logic ci, bx, sm, co, less;
    if (i == 0) begin : g_lsb
      assign ci   = carry_in;
      assign less = set_bit;
    end else begin : g_up
      assign ci   = slice[i-1].co;
      assign less = 1'b0;
    end
    assign bx = b_in[i] ^ b_flip;
    assign sm = a_in[i] ^ bx ^ ci;
    assign co = (a_in[i] & bx) | (a_in[i] & ci) | (bx & ci);
    assign result[i] = op_sel[1] ? (op_sel[0] ? less : sm)
                                 : (op_sel[0] ? (a_in[i] | b_in[i]) : (a_in[i] & b_in[i]));
  end

  assign carry_out = slice[WIDTH-1].co;
  assign ovf       = slice[WIDTH-1].co ^ slice[WIDTH-1].ci;
  assign set_bit   = slice[WIDTH-1].sm ^ ovf;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide_sum;
  assign b_eff    = b_in ^ {WIDTH{b_flip}};
  assign wide_sum = {1'b0, a_in} + {1'b0, b_eff} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (op_sel == 2'b00) begin
      // R1
      and_res_chk: assert (result == (a_in & b_in)) else $error("and mismatch");
    end
    if (op_sel == 2'b01) begin
      // R2
      or_res_chk: assert (result == (a_in | b_in)) else $error("or mismatch");
    end
    if (op_sel == 2'b10) begin
      // R3
      sum_res_chk: assert ({carry_out, result} == wide_sum) else $error("sum mismatch");
    end
    // R8
    carry_any_op_chk: assert (carry_out == wide_sum[WIDTH]) else $error("carry mismatch");
    // R5
    ovf_sign_chk: assert (ovf == ((a_in[WIDTH-1] == b_eff[WIDTH-1]) &&
                                  (wide_sum[WIDTH-1] != a_in[WIDTH-1]))) else $error("ovf mismatch");
    if (op_sel == 2'b11 && b_flip && carry_in) begin
      // R6
      slt_res_chk: assert (result[0] == ($signed(a_in) < $signed(b_in))) else $error("slt mismatch");
    end
    if (op_sel == 2'b11) begin
      // R7
      slt_upper_chk: assert (result[WIDTH-1:1] == '0) else $error("slt upper bits set");
    end
  end
endmodule

// File: tb/tb_bitslice_alu.sv
module tb_bitslice_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] a, b, res;
  logic flip, cin, co, ov;
  logic [1:0] op;
  bitslice_alu #(.WIDTH(32)) dut (.a_in(a), .b_in(b), .b_flip(flip), .carry_in(cin),
                                  .op_sel(op), .result(res), .carry_out(co), .ovf(ov));

  logic [3:0] na, nb, nres;
  logic nflip, ncin, nco, nov;
  logic [1:0] nop;
  bitslice_alu #(.WIDTH(4)) dut_narrow (.a_in(na), .b_in(nb), .b_flip(nflip), .carry_in(ncin),
                                        .op_sel(nop), .result(nres), .carry_out(nco), .ovf(nov));

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // tag, a, b, flip, cin, op, result, carry_out, ovf
  localparam int NV = 15;
  localparam logic [105:0] VEC [NV] = '{
    {4'd1, 32'hF0F000FF, 32'h0FF00F0F, 1'b0, 1'b0, 2'b00, 32'h00F0000F, 1'b1, 1'b0}, // R1
    {4'd2, 32'hF0F000FF, 32'h0FF00F0F, 1'b0, 1'b0, 2'b01, 32'hFFF00FFF, 1'b1, 1'b0}, // R2
    {4'd1, 32'hF0F000FF, 32'h0FF00F0F, 1'b1, 1'b0, 2'b00, 32'h00F0000F, 1'b1, 1'b0}, // R1 flip ignored
    {4'd5, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0, 2'b10, 32'h80000000, 1'b0, 1'b1}, // R5
    {4'd3, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0, 2'b10, 32'h00000000, 1'b1, 1'b0}, // R3 full ripple
    {4'd3, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 2'b10, 32'h00000000, 1'b1, 1'b0}, // R3 carry_in
    {4'd4, 32'h00000005, 32'h00000003, 1'b1, 1'b1, 2'b10, 32'h00000002, 1'b1, 1'b0}, // R4
    {4'd4, 32'h00000003, 32'h00000005, 1'b1, 1'b1, 2'b10, 32'hFFFFFFFE, 1'b0, 1'b0}, // R4 borrow
    {4'd5, 32'h80000000, 32'h00000001, 1'b1, 1'b1, 2'b10, 32'h7FFFFFFF, 1'b1, 1'b1}, // R5 sub
    {4'd6, 32'h00000003, 32'h00000005, 1'b1, 1'b1, 2'b11, 32'h00000001, 1'b0, 1'b0}, // R6
    {4'd6, 32'h00000005, 32'h00000003, 1'b1, 1'b1, 2'b11, 32'h00000000, 1'b1, 1'b0}, // R6
    {4'd6, 32'h7FFFFFFF, 32'h80000000, 1'b1, 1'b1, 2'b11, 32'h00000000, 1'b0, 1'b1}, // R6 overflow
    {4'd6, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b1, 2'b11, 32'h00000001, 1'b1, 1'b1}, // R6 overflow
    {4'd6, 32'h12345678, 32'h12345678, 1'b1, 1'b1, 2'b11, 32'h00000000, 1'b1, 1'b0}, // R6 equal
    {4'd7, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b1, 2'b11, 32'h00000001, 1'b1, 1'b0}  // R7
  };

  function automatic logic [33:0] model32(input logic [31:0] x, input logic [31:0] y,
                                          input logic f, input logic c, input logic [1:0] o);
    logic [31:0] ye = f ? ~y : y;
    logic [32:0] s  = {1'b0, x} + {1'b0, ye} + {32'd0, c};
    logic v = (x[31] == ye[31]) && (s[31] != x[31]);
    logic [31:0] r;
    case (o)
      2'b00:   r = x & y;
      2'b01:   r = x | y;
      2'b10:   r = s[31:0];
      default: r = {31'd0, f & c ? ($signed(x) < $signed(y)) : (s[31] ^ v)};
    endcase
    return {r, s[32], v};
  endfunction

  function automatic logic [5:0] model4(input logic [3:0] x, input logic [3:0] y,
                                        input logic f, input logic c, input logic [1:0] o);
    logic [3:0] ye = f ? ~y : y;
    logic [4:0] s  = {1'b0, x} + {1'b0, ye} + {4'd0, c};
    logic v = (x[3] == ye[3]) && (s[3] != x[3]);
    logic [3:0] r;
    case (o)
      2'b00:   r = x & y;
      2'b01:   r = x | y;
      2'b10:   r = s[3:0];
      default: r = {3'd0, s[3] ^ v};
    endcase
    return {r, s[4], v};
  endfunction

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; flip = 0; cin = 0; op = 2'b00;
    na = '0; nb = '0; nflip = 0; ncin = 0; nop = 2'b00;
    @(negedge clk);
    chk(1, "idle result", res, 32'd0);            // R1 all-zero inputs
    chk(8, "idle carry/ovf", {30'd0, co, ov}, 32'd0); // R8

    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      a = VEC[k][101:70]; b = VEC[k][69:38]; flip = VEC[k][37]; cin = VEC[k][36]; op = VEC[k][35:34];
      @(negedge clk);
      chk(int'(VEC[k][105:102]), "table result", res, VEC[k][33:2]);
      chk(8, "table carry_out", {31'd0, co}, {31'd0, VEC[k][1]});
      chk(5, "table ovf", {31'd0, ov}, {31'd0, VEC[k][0]});
    end

    // random operands over all five operations: R1 R2 R3 R4 R6 R7 R8
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = (k % 10 == 0) ? ra : $urandom;
      for (int m = 0; m < 5; m++) begin
        logic [33:0] e;
        int tag;
        @(posedge clk);
        a = ra; b = rb;
        case (m)
          0: begin op = 2'b00; flip = k[0]; cin = k[1]; tag = 1; end
          1: begin op = 2'b01; flip = k[0]; cin = k[1]; tag = 2; end
          2: begin op = 2'b10; flip = 0;    cin = k[0]; tag = 3; end
          3: begin op = 2'b10; flip = 1;    cin = 1;    tag = 4; end
          default: begin op = 2'b11; flip = 1; cin = 1; tag = 6; end
        endcase
        e = model32(ra, rb, flip, cin, op);
        @(negedge clk);
        chk(tag, "random result", res, e[33:2]);
        chk(8, "random carry_out", {31'd0, co}, {31'd0, e[1]});
        chk(5, "random ovf", {31'd0, ov}, {31'd0, e[0]});
      end
    end

    // exhaustive narrow instance: R5 R6 R7 at WIDTH 4
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int fc = 0; fc < 4; fc++)
          for (int o = 0; o < 4; o++) begin
            logic [5:0] e;
            @(posedge clk);
            na = 4'(x); nb = 4'(y); nflip = fc[1]; ncin = fc[0]; nop = 2'(o);
            e = model4(na, nb, nflip, ncin, nop);
            @(negedge clk);
            chk((o == 3) ? 7 : o + 1, "narrow result", {28'd0, nres}, {28'd0, e[5:2]});
            chk(8, "narrow carry_out", {31'd0, nco}, {31'd0, e[1]});
            chk(5, "narrow ovf", {31'd0, nov}, {31'd0, e[0]});
          end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule